// File: doc/BRIEF.md
# Prioritized Timing Reference Selector

This block keeps a small working table of reference pairings. Each pairing names a time-of-day source and a separate one-pulse-per-second source. From that table it chooses the pairing that will discipline the local oscillator. A pairing can be chosen only when it is enabled, has a nonzero priority, and both of its sources report valid in the same cycle. Among the pairings that qualify, the smallest priority number wins. When two qualifying pairings share a priority, the lower entry index wins.

A host edits the table through a one-cycle command port. The commands write a whole entry, enable or disable an entry, delete an entry, or change its priority. Two more commands reload the whole table, either from the built-in default or from a user table that persistent storage outside the block supplies. After reset the block loads the user table if one is present, and the default table otherwise. Every change re-runs the selection, and so does every change of source validity. When nothing qualifies, the block drops its valid flag and keeps the last chosen source IDs, so the oscillator can freewheel on them.

Top module: `rtsel_top`

## Requirements
- R1: On the first cycle after reset the working table is loaded from `user_tbl` when `user_present` is 1, and from the default table otherwise. The reset state of the outputs is `sel_valid`=0, `sel_idx`=0, `sel_tsrc`=0, `sel_psrc`=0.
- R2: In the default table, entry i (i < 7) is enabled, has priority i+1, time source i and PPS source i. Entry 7 is the self reference: time and PPS source 15, disabled, priority 0.
- R3: An entry qualifies only when its enable bit is 1, its priority is nonzero, bit `tsrc` of the effective time validity is 1 and bit `psrc` of the effective PPS validity is 1. An enabled entry with priority 0 is never selected.
- R4: Among qualifying entries the one with the smallest priority value is selected. A tie goes to the lower index.
- R5: The time source and the PPS source of an entry are independent. Any time ID can pair with any PPS ID, and the outputs report both IDs of the selected entry.
- R6: Source ID 15 is the self reference and counts as valid for both time and PPS, whatever `time_ok` and `pps_ok` say.
- R7: Commands act when `cmd_valid` is 1, with `cmd_op` coded as follows: 1 writes the entry {`cmd_en`,`cmd_prio`,`cmd_tsrc`,`cmd_psrc`} at `cmd_idx`; 2 enables it; 3 disables it; 4 deletes it (all fields zero); 5 sets its priority to `cmd_prio`. Each change re-runs the selection.
- R8: `cmd_op` 6 reloads the default table. `cmd_op` 7 reloads `user_tbl` if `user_present` is 1, and the default table otherwise. Both may be issued at any time. In `user_tbl`, entry i occupies bits [12i+11:12i], packed as {en, prio[2:0], tsrc[3:0], psrc[3:0]} from MSB to LSB.
- R9: When a selected source loses validity, the selection moves to the next qualifying entry in priority order.
- R10: When no entry qualifies, `sel_valid` is 0 and `sel_idx`, `sel_tsrc` and `sel_psrc` keep their last values.
- R11: A change of `time_ok`/`pps_ok`, or a command, shows at the selection outputs after the second rising edge and not after the first.
- R12: `eff_time_ok` and `eff_pps_ok` show `time_ok` and `pps_ok` with bit 15 forced to 1. They are registered, one rising edge after the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code (see R7, R8) |
| cmd_idx | input | 3 | Target entry index |
| cmd_en | input | 1 | Enable bit for a write |
| cmd_prio | input | 3 | Priority for a write or a priority change |
| cmd_tsrc | input | 4 | Time source ID for a write |
| cmd_psrc | input | 4 | PPS source ID for a write |
| user_present | input | 1 | A user table is available |
| user_tbl | input | 96 | User table, 8 packed entries |
| time_ok | input | 16 | Per-source time validity |
| pps_ok | input | 16 | Per-source PPS validity |
| sel_valid | output | 1 | A pairing qualifies |
| sel_idx | output | 3 | Selected entry index |
| sel_tsrc | output | 4 | Selected time source ID |
| sel_psrc | output | 4 | Selected PPS source ID |
| eff_time_ok | output | 16 | Registered effective time validity |
| eff_pps_ok | output | 16 | Registered effective PPS validity |

## Verification
A corrupted table entry shows up two edges after the fault. The selection then either lands on a pairing whose sources were not both valid, or reports IDs that do not match the entry it names. The checker compares the selected IDs against the table as it stood one cycle earlier. A stuck or lost validity bit shows on the effective validity outputs after one edge, and it moves or freezes the selection one edge after that. A hold fault shows as IDs that change while `sel_valid` is low. The directed tests arrange validity patterns in which exactly one entry should win, so a wrong priority compare or a wrong tie-break points to a specific index.

// File: rtl/rtsel_pkg.sv
package rtsel_pkg;
    localparam int PRIO_W  = 3;
    localparam int SRC_W   = 4;
    localparam int NUM_SRC = 1 << SRC_W;
    localparam int ENT_W   = 1 + PRIO_W + 2 * SRC_W;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic  en;
        prio_t prio;
        src_t  tsrc;
        src_t  psrc;
    } entry_t;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_WRITE    = 3'd1,
        OP_ENABLE   = 3'd2,
        OP_DISABLE  = 3'd3,
        OP_DELETE   = 3'd4,
        OP_SETPRIO  = 3'd5,
        OP_LOAD_DEF = 3'd6,
        OP_LOAD_USR = 3'd7
    } op_e;

    // Factory pairing: the last slot is the self reference, parked.
    // The others rank by index.
    function automatic entry_t dflt_entry(input int idx, input int n, input src_t self_id);
        entry_t e;
        if (idx == n - 1) begin
            e.en   = 1'b0;
            e.prio = '0;
            e.tsrc = self_id;
            e.psrc = self_id;
        end else begin
            e.en   = 1'b1;
            e.prio = prio_t'(idx + 1);
            e.tsrc = src_t'(idx);
            e.psrc = src_t'(idx);
        end
        return e;
    endfunction
endpackage

// File: rtl/rtsel_table.sv
module rtsel_table
    import rtsel_pkg::*;
#(
    parameter int   NUM_ENT = 8,
    parameter src_t SELF_ID = 4'd15,
    localparam int  IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_op,
    input  logic [IDX_W-1:0]       cmd_idx,
    input  logic                   cmd_en,
    input  prio_t                  cmd_prio,
    input  src_t                   cmd_tsrc,
    input  src_t                   cmd_psrc,
    input  logic                   user_present,
    input  entry_t [NUM_ENT-1:0]   user_tbl,
    output entry_t [NUM_ENT-1:0]   tbl
);
    typedef entry_t [NUM_ENT-1:0] tbl_t;

    typedef struct packed {
        tbl_t tbl;
        logic boot;
    } st_t;

    function automatic tbl_t build_dflt();
        tbl_t t;
        for (int i = 0; i < NUM_ENT; i++) begin
            t[i] = dflt_entry(i, NUM_ENT, SELF_ID);
        end
        return t;
    endfunction

    localparam tbl_t DFLT = build_dflt();

    st_t st_d, st_q;
    op_e op;
    logic idx_ok;

    assign op     = op_e'(cmd_op);
    assign idx_ok = (int'(cmd_idx) < NUM_ENT);

    always_comb begin
        st_d = st_q;
        if (st_q.boot) begin
            // First cycle out of reset: adopt the stored table if one exists.
            st_d.boot = 1'b0;
            st_d.tbl  = user_present ? user_tbl : DFLT;
        end else if (cmd_valid) begin
            case (op)
                OP_WRITE:    if (idx_ok) st_d.tbl[cmd_idx] = '{en: cmd_en, prio: cmd_prio,
                                                               tsrc: cmd_tsrc, psrc: cmd_psrc};
                OP_ENABLE:   if (idx_ok) st_d.tbl[cmd_idx].en = 1'b1;
                OP_DISABLE:  if (idx_ok) st_d.tbl[cmd_idx].en = 1'b0;
                OP_DELETE:   if (idx_ok) st_d.tbl[cmd_idx] = '0;
                OP_SETPRIO:  if (idx_ok) st_d.tbl[cmd_idx].prio = cmd_prio;
                OP_LOAD_DEF: st_d.tbl = DFLT;
                OP_LOAD_USR: st_d.tbl = user_present ? user_tbl : DFLT;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tbl  <= DFLT;
            st_q.boot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl = st_q.tbl;
endmodule

// File: rtl/rtsel_qual.sv
module rtsel_qual
    import rtsel_pkg::*;
#(
    parameter int   NUM_ENT = 8,
    parameter src_t SELF_ID = 4'd15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   time_ok,
    input  logic [NUM_SRC-1:0]   pps_ok,
    input  entry_t [NUM_ENT-1:0] tbl,
    output logic [NUM_SRC-1:0]   eff_t,
    output logic [NUM_SRC-1:0]   eff_p,
    output logic [NUM_ENT-1:0]   qual
);
    localparam logic [NUM_SRC-1:0] SELF_MASK = NUM_SRC'(1) << SELF_ID;

    typedef struct packed {
        logic [NUM_SRC-1:0] t;
        logic [NUM_SRC-1:0] p;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.t = time_ok | SELF_MASK;
        st_d.p = pps_ok  | SELF_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.t <= SELF_MASK;
            st_q.p <= SELF_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_t = st_q.t;
    assign eff_p = st_q.p;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign qual[g] = tbl[g].en && (tbl[g].prio != '0)
                      && st_q.t[tbl[g].tsrc] && st_q.p[tbl[g].psrc];
    end
endmodule

// File: rtl/rtsel_pick.sv
module rtsel_pick
    import rtsel_pkg::*;
#(
    parameter int  NUM_ENT = 8,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic [NUM_ENT-1:0]   qual,
    input  entry_t [NUM_ENT-1:0] tbl,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);
    prio_t best;

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '1;
        // Ascending scan with a strict compare keeps the lower index on ties.
        for (int i = 0; i < NUM_ENT; i++) begin
            if (qual[i] && (!hit || tbl[i].prio < best)) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                best = tbl[i].prio;
            end
        end
    end
endmodule

// File: rtl/rtsel_top.sv
module rtsel_top
    import rtsel_pkg::*;
#(
    parameter int   NUM_ENT = 8,
    parameter src_t SELF_ID = 4'd15,
    localparam int  IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [IDX_W-1:0]           cmd_idx,
    input  logic                       cmd_en,
    input  logic [PRIO_W-1:0]          cmd_prio,
    input  logic [SRC_W-1:0]           cmd_tsrc,
    input  logic [SRC_W-1:0]           cmd_psrc,
    input  logic                       user_present,
    input  logic [NUM_ENT*ENT_W-1:0]   user_tbl,
    input  logic [NUM_SRC-1:0]         time_ok,
    input  logic [NUM_SRC-1:0]         pps_ok,
    output logic                       sel_valid,
    output logic [IDX_W-1:0]           sel_idx,
    output logic [SRC_W-1:0]           sel_tsrc,
    output logic [SRC_W-1:0]           sel_psrc,
    output logic [NUM_SRC-1:0]         eff_time_ok,
    output logic [NUM_SRC-1:0]         eff_pps_ok
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        src_t             tsrc;
        src_t             psrc;
    } sel_t;

    entry_t [NUM_ENT-1:0] tbl;
    entry_t [NUM_ENT-1:0] usr;
    logic [NUM_ENT-1:0]   qual;
    logic                 pick_hit;
    logic [IDX_W-1:0]     pick_idx;
    sel_t                 sel_d, sel_q;

    assign usr = user_tbl;

    rtsel_table #(.NUM_ENT(NUM_ENT), .SELF_ID(SELF_ID)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_en(cmd_en), .cmd_prio(cmd_prio), .cmd_tsrc(cmd_tsrc), .cmd_psrc(cmd_psrc),
        .user_present(user_present), .user_tbl(usr), .tbl(tbl)
    );

    rtsel_qual #(.NUM_ENT(NUM_ENT), .SELF_ID(SELF_ID)) u_qual (
        .clk(clk), .rst_n(rst_n), .time_ok(time_ok), .pps_ok(pps_ok),
        .tbl(tbl), .eff_t(eff_time_ok), .eff_p(eff_pps_ok), .qual(qual)
    );

    rtsel_pick #(.NUM_ENT(NUM_ENT)) u_pick (
        .qual(qual), .tbl(tbl), .hit(pick_hit), .idx(pick_idx)
    );

    always_comb begin
        sel_d       = sel_q;
        sel_d.valid = pick_hit;
        if (pick_hit) begin
            sel_d.idx  = pick_idx;
            sel_d.tsrc = tbl[pick_idx].tsrc;
            sel_d.psrc = tbl[pick_idx].psrc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_valid = sel_q.valid;
    assign sel_idx   = sel_q.idx;
    assign sel_tsrc  = sel_q.tsrc;
    assign sel_psrc  = sel_q.psrc;
endmodule

// File: rtl/rtsel_chk.sv
module rtsel_chk
    import rtsel_pkg::*;
#(
    parameter int   NUM_ENT = 8,
    parameter src_t SELF_ID = 4'd15,
    localparam int  IDX_W   = $clog2(NUM_ENT)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel_valid,
    input logic [IDX_W-1:0]     sel_idx,
    input logic [SRC_W-1:0]     sel_tsrc,
    input logic [SRC_W-1:0]     sel_psrc,
    input logic [NUM_SRC-1:0]   eff_time_ok,
    input logic [NUM_SRC-1:0]   eff_pps_ok,
    input entry_t [NUM_ENT-1:0] tbl
);
    logic [NUM_SRC-1:0]   prev_t, prev_p;
    entry_t [NUM_ENT-1:0] prev_tbl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_t   <= '0;
            prev_p   <= '0;
            prev_tbl <= '0;
        end else begin
            prev_t   <= eff_time_ok;
            prev_p   <= eff_pps_ok;
            prev_tbl <= tbl;
        end
    end

    // R3: both halves of the chosen pairing were valid when it was chosen
    a_r3_both_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (prev_t[sel_tsrc] && prev_p[sel_psrc]));

    // R3: the chosen entry was enabled with a nonzero priority
    a_r3_entry_live: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (prev_tbl[sel_idx].en && prev_tbl[sel_idx].prio != '0));

    // R5: reported IDs belong to the reported entry
    a_r5_ids_match: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_tsrc == prev_tbl[sel_idx].tsrc && sel_psrc == prev_tbl[sel_idx].psrc));

    // R10: no qualifier means the last choice is frozen
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> ($stable(sel_idx) && $stable(sel_tsrc) && $stable(sel_psrc)));

    // R6: the self reference never reads invalid
    a_r6_self_ok: assert property (@(posedge clk) disable iff (!rst_n)
        eff_time_ok[SELF_ID] && eff_pps_ok[SELF_ID]);
endmodule

bind rtsel_top rtsel_chk #(.NUM_ENT(NUM_ENT), .SELF_ID(SELF_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .sel_tsrc(sel_tsrc), .sel_psrc(sel_psrc), .eff_time_ok(eff_time_ok),
    .eff_pps_ok(eff_pps_ok), .tbl(tbl)
);

// File: tb/rtsel_top_test.sv
`timescale 1ns/1ps
module rtsel_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic        cmd_en = 1'b0;
    logic [2:0]  cmd_prio = '0;
    logic [3:0]  cmd_tsrc = '0;
    logic [3:0]  cmd_psrc = '0;
    logic        user_present = 1'b0;
    logic [95:0] user_tbl = '0;
    logic [15:0] time_ok = '0;
    logic [15:0] pps_ok = '0;
    logic        sel_valid;
    logic [2:0]  sel_idx;
    logic [3:0]  sel_tsrc, sel_psrc;
    logic [15:0] eff_time_ok, eff_pps_ok;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    rtsel_top uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_en(cmd_en), .cmd_prio(cmd_prio),
        .cmd_tsrc(cmd_tsrc), .cmd_psrc(cmd_psrc), .user_present(user_present),
        .user_tbl(user_tbl), .time_ok(time_ok), .pps_ok(pps_ok),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_tsrc(sel_tsrc),
        .sel_psrc(sel_psrc), .eff_time_ok(eff_time_ok), .eff_pps_ok(eff_pps_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_sel(input string req, input logic v, input int idx, input int ts, input int ps);
        chk({req, " valid"}, 32'(sel_valid), 32'(v));
        chk({req, " idx"},   32'(sel_idx),   32'(idx));
        chk({req, " tsrc"},  32'(sel_tsrc),  32'(ts));
        chk({req, " psrc"},  32'(sel_psrc),  32'(ps));
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic set_valid(input logic [15:0] t, input logic [15:0] p);
        @(negedge clk);
        time_ok = t;
        pps_ok  = p;
        settle();
    endtask

    task automatic cmd(input int op, input int idx, input logic en, input int prio,
                       input int ts, input int ps);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_idx   = 3'(idx);
        cmd_en    = en;
        cmd_prio  = 3'(prio);
        cmd_tsrc  = 4'(ts);
        cmd_psrc  = 4'(ps);
        @(negedge clk);
        cmd_valid = 1'b0;
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        settle();
        chk_sel("R1 reset", 1'b0, 0, 0, 0);
        chk("R6 self time", 32'(eff_time_ok), 32'h8000);
        chk("R6 self pps",  32'(eff_pps_ok),  32'h8000);
    endtask

    task automatic t_default();
        set_valid(16'hFFFF, 16'hFFFF);
        chk_sel("R2 all valid", 1'b1, 0, 0, 0);
        set_valid(16'hFFFE, 16'hFFFE);
        chk_sel("R9 fall to next", 1'b1, 1, 1, 1);
        set_valid(16'h0040, 16'h0040);
        chk_sel("R2 entry six", 1'b1, 6, 6, 6);
        set_valid(16'h0000, 16'h0000);
        chk_sel("R10 hold", 1'b0, 6, 6, 6);
        set_valid(16'h0040, 16'h0000);
        chk_sel("R3 time only", 1'b0, 6, 6, 6);
    endtask

    task automatic t_pair();
        cmd(6, 0, 0, 0, 0, 0);
        cmd(1, 2, 1'b1, 1, 3, 9);
        set_valid(16'h0008, 16'h0200);
        chk_sel("R5 cross pair", 1'b1, 2, 3, 9);
        set_valid(16'h0008, 16'h0000);
        chk_sel("R10 pps lost", 1'b0, 2, 3, 9);
    endtask

    task automatic t_tie();
        cmd(6, 0, 0, 0, 0, 0);
        set_valid(16'h0030, 16'h0030);
        chk_sel("R4 lower prio value", 1'b1, 4, 4, 4);
        cmd(5, 5, 0, 1, 0, 0);
        chk_sel("R4 reprioritised", 1'b1, 5, 5, 5);
        cmd(5, 4, 0, 1, 0, 0);
        chk_sel("R4 tie lower index", 1'b1, 4, 4, 4);
    endtask

    task automatic t_cmds();
        cmd(6, 0, 0, 0, 0, 0);
        set_valid(16'hFFFF, 16'hFFFF);
        chk_sel("R7 base", 1'b1, 0, 0, 0);
        cmd(3, 0, 0, 0, 0, 0);
        chk_sel("R7 disable", 1'b1, 1, 1, 1);
        cmd(2, 0, 0, 0, 0, 0);
        chk_sel("R7 enable", 1'b1, 0, 0, 0);
        cmd(4, 0, 0, 0, 0, 0);
        chk_sel("R7 delete", 1'b1, 1, 1, 1);
        cmd(5, 0, 0, 1, 0, 0);
        chk_sel("R7 deleted stays off", 1'b1, 1, 1, 1);
        cmd(2, 0, 0, 0, 0, 0);
        chk_sel("R7 re-enabled", 1'b1, 0, 0, 0);
    endtask

    task automatic t_self();
        cmd(6, 0, 0, 0, 0, 0);
        set_valid(16'h0000, 16'h0000);
        cmd(2, 7, 0, 0, 0, 0);
        chk_sel("R3 prio zero excluded", 1'b0, 0, 0, 0);
        cmd(5, 7, 0, 3, 0, 0);
        chk_sel("R6 self selected", 1'b1, 7, 15, 15);
        set_valid(16'h0004, 16'h0004);
        chk_sel("R4 tie with self", 1'b1, 2, 2, 2);
    endtask

    task automatic t_tables();
        user_tbl = '0;
        user_tbl[3*12 +: 12] = {1'b1, 3'd1, 4'd10, 4'd11};
        user_present = 1'b1;
        cmd(6, 0, 0, 0, 0, 0);
        set_valid(16'hFFFF, 16'hFFFF);
        chk_sel("R8 default", 1'b1, 0, 0, 0);
        cmd(7, 0, 0, 0, 0, 0);
        chk_sel("R8 user load", 1'b1, 3, 10, 11);
        cmd(6, 0, 0, 0, 0, 0);
        chk_sel("R8 default reload", 1'b1, 0, 0, 0);
        user_present = 1'b0;
        cmd(1, 0, 1'b0, 1, 0, 0);
        chk_sel("R7 write disabled", 1'b1, 1, 1, 1);
        cmd(7, 0, 0, 0, 0, 0);
        chk_sel("R8 user absent", 1'b1, 0, 0, 0);
    endtask

    task automatic t_boot();
        user_present = 1'b1;
        do_reset();
        settle();
        chk_sel("R1 boot user", 1'b1, 3, 10, 11);
        user_present = 1'b0;
        do_reset();
        settle();
        chk_sel("R1 boot default", 1'b1, 0, 0, 0);
    endtask

    task automatic t_latency();
        cmd(6, 0, 0, 0, 0, 0);
        set_valid(16'hFFFF, 16'hFFFF);
        @(negedge clk);
        time_ok = 16'h7FFE;
        @(posedge clk);
        #1;
        chk("R12 eff time", 32'(eff_time_ok), 32'hFFFE);
        chk("R11 first edge", 32'(sel_idx), 32'd0);
        @(posedge clk);
        #1;
        chk("R11 second edge", 32'(sel_idx), 32'd1);
        chk("R12 eff pps", 32'(eff_pps_ok), 32'hFFFF);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default();
        t_pair();
        t_tie();
        t_cmds();
        t_self();
        t_tables();
        t_boot();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule